// File: doc/BRIEF.md
# Four-Level Priority Interrupt Arbiter

This block collects interrupt requests from three kinds of sources and picks the one the core should service next. It presents that source's vector address and the new priority level to the core. Exception and software-trap sources have levels fixed in hardware. Debug-unit sources and peripheral sources each take a 2-bit select field. The select field both turns the source off and places it on a level, and each of the two classes has its own range of levels. A single lowest software request sits below every numbered level.

There are four levels, 0 (lowest) to 3 (highest), and each level has its own priority encoder. A selector combines the four results with the core's 2-bit mask. The chosen request is registered, so the core sees it one cycle after the inputs that produced it. The vector is an aligned two-word slot in a table that starts at a base address set by a parameter.

Source numbering, from index 0 up:
- 0: illegal instruction
- 1: hardware stack overflow
- 2: misaligned data access
- 3 to 6: software traps #3, #2, #1, #0
- next NUM_DBG indices: debug sources
- next NUM_PER indices: peripheral sources
- last index: the lowest software request

Top module: `irq_prio_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `irq_valid`=0, `irq_vector`=0 and `irq_level`=0.
- R2: Outputs are registered and reflect the inputs sampled at the previous rising edge. With no request line high, `irq_valid` is 0.
- R3: Sources 0, 1 and 2 are fixed at level 3. Sources 3, 4, 5 and 6 are fixed at levels 3, 2, 1 and 0 respectively.
- R4: A debug source's select field (2 bits at position 2k of `dbg_sel` for debug source k) maps 00 to disabled, 01 to level 1, 10 to level 2 and 11 to level 3.
- R5: A peripheral source's select field (2 bits at position 2k of `per_sel` for peripheral source k) maps 00 to disabled, 01 to level 0, 10 to level 1 and 11 to level 2.
- R6: Among eligible requests, the one on the highest level wins.
- R7: Among eligible requests on the same level, the lowest source index wins.
- R8: A numbered-level request is eligible only when its level is greater than or equal to `core_mask`. Level 3 is therefore never masked.
- R9: When valid, `irq_vector` equals VEC_BASE plus twice the winning source index, and `irq_level` is the winner's level.
- R10: The lowest software request (the last index) does not depend on `core_mask`. It is presented, with level 0, only when no other request is eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Request lines, one per source, numbered as above |
| dbg_sel | input | 2*NUM_DBG | Level select fields of the debug sources |
| per_sel | input | 2*NUM_PER | Level select fields of the peripheral sources |
| core_mask | input | 2 | Current core priority mask |
| irq_valid | output | 1 | A request is presented |
| irq_vector | output | VEC_W | Vector table address of the winner |
| irq_level | output | 2 | New priority level of the winner |

## Verification
The first pattern is every combination of request lines under all four mask values, with one fixed set of select fields. This separates level ordering from index ordering, and shows where the mask cuts off levels and the lowest software request takes over. The second pattern is a pseudo-random spread of request sets over the whole select space of a small configuration. It exercises the disabled code and the shifted debug and peripheral encodings against each other. Directed cases pin down each fixed level, each select code, and the tie between two sources on the same level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Exceptions (3) plus four fixed software traps precede programmable sources
    localparam int EXC_SRCS = 7;

    typedef struct packed {
        logic       en;
        logic [1:0] lvl;
    } src_attr_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] lvl;
    } grant_t;

    function automatic logic [1:0] exc_level(input int idx);
        if (idx < 3) return 2'd3;
        return 2'(6 - idx);
    endfunction

    // Debug select: 00 off, otherwise the code is the level (1..3)
    function automatic src_attr_t dbg_attr(input logic [1:0] sel);
        src_attr_t a;
        a.en  = (sel != 2'b00);
        a.lvl = sel;
        return a;
    endfunction

    // Peripheral select: 00 off, otherwise level is code minus one (0..2)
    function automatic src_attr_t per_attr(input logic [1:0] sel);
        src_attr_t a;
        a.en  = (sel != 2'b00);
        a.lvl = sel - 2'd1;
        return a;
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_arb_pkg::*;
#(
    parameter int NUM_DBG = 4,
    parameter int NUM_PER = 16,
    localparam int W = EXC_SRCS + NUM_DBG + NUM_PER
) (
    input  logic [W-1:0]          req,
    input  logic [2*NUM_DBG-1:0]  dbg_sel,
    input  logic [2*NUM_PER-1:0]  per_sel,
    output logic [3:0][W-1:0]     pend
);

    for (genvar i = 0; i < W; i++) begin : g_src
        src_attr_t attr;
        if (i < EXC_SRCS) begin : g_exc
            assign attr = '{en: 1'b1, lvl: exc_level(i)};
        end else if (i < EXC_SRCS + NUM_DBG) begin : g_dbg
            assign attr = dbg_attr(dbg_sel[2*(i-EXC_SRCS) +: 2]);
        end else begin : g_per
            assign attr = per_attr(per_sel[2*(i-EXC_SRCS-NUM_DBG) +: 2]);
        end
        for (genvar l = 0; l < 4; l++) begin : g_lvl
            assign pend[l][i] = req[i] & attr.en & (attr.lvl == 2'(l));
        end
    end

endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
    parameter int W     = 27,
    parameter int IDX_W = 5
) (
    input  logic [W-1:0]     pend,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_grant_sel.sv
module irq_grant_sel
    import irq_arb_pkg::*;
#(
    parameter int IDX_W   = 5,
    parameter int LOW_IDX = 27
) (
    input  logic [3:0]            hit,
    input  logic [3:0][IDX_W-1:0] idx,
    input  logic [1:0]            mask,
    input  logic                  low_req,
    output grant_t                grant,
    output logic [IDX_W-1:0]      win_idx
);

    always_comb begin
        grant   = '0;
        win_idx = IDX_W'(LOW_IDX);
        // ascending scan: the last eligible level assigned is the highest
        for (int l = 0; l < 4; l++) begin
            if (hit[l] && (2'(l) >= mask)) begin
                grant.valid = 1'b1;
                grant.lvl   = 2'(l);
                win_idx     = idx[l];
            end
        end
        if (!grant.valid && low_req) begin
            grant.valid = 1'b1;
            grant.lvl   = 2'd0;
            win_idx     = IDX_W'(LOW_IDX);
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_DBG = 4,
    parameter int NUM_PER = 16,
    parameter int VEC_W   = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 'h80,
    localparam int NUM_SRC = EXC_SRCS + NUM_DBG + NUM_PER + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   irq_req,
    input  logic [2*NUM_DBG-1:0] dbg_sel,
    input  logic [2*NUM_PER-1:0] per_sel,
    input  logic [1:0]           core_mask,
    output logic                 irq_valid,
    output logic [VEC_W-1:0]     irq_vector,
    output logic [1:0]           irq_level
);

    localparam int NUMBERED = NUM_SRC - 1;
    localparam int IDX_W    = $clog2(NUM_SRC);

    logic [3:0][NUMBERED-1:0] pend;
    logic [3:0]               lvl_hit;
    logic [3:0][IDX_W-1:0]    lvl_idx;
    grant_t                   grant;
    logic [IDX_W-1:0]         win_idx;
    logic [VEC_W-1:0]         next_vec;

    irq_src_map #(
        .NUM_DBG (NUM_DBG),
        .NUM_PER (NUM_PER)
    ) u_map (
        .req     (irq_req[NUMBERED-1:0]),
        .dbg_sel (dbg_sel),
        .per_sel (per_sel),
        .pend    (pend)
    );

    for (genvar l = 0; l < 4; l++) begin : g_level
        irq_level_pick #(
            .W     (NUMBERED),
            .IDX_W (IDX_W)
        ) u_pick (
            .pend (pend[l]),
            .hit  (lvl_hit[l]),
            .idx  (lvl_idx[l])
        );
    end

    irq_grant_sel #(
        .IDX_W   (IDX_W),
        .LOW_IDX (NUMBERED)
    ) u_sel (
        .hit     (lvl_hit),
        .idx     (lvl_idx),
        .mask    (core_mask),
        .low_req (irq_req[NUMBERED]),
        .grant   (grant),
        .win_idx (win_idx)
    );

    assign next_vec = VEC_BASE + VEC_W'({win_idx, 1'b0});

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
            irq_level  <= 2'd0;
        end else begin
            irq_valid  <= grant.valid;
            irq_vector <= next_vec;
            irq_level  <= grant.lvl;
        end
    end

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int NUM_DBG = 4,
    parameter int NUM_PER = 16,
    parameter int VEC_W   = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 'h80,
    localparam int NUM_SRC = EXC_SRCS + NUM_DBG + NUM_PER + 1
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [1:0]         dbg0_sel,
    input logic [1:0]         per0_sel,
    input logic [1:0]         core_mask,
    input logic               irq_valid,
    input logic [VEC_W-1:0]   irq_vector,
    input logic [1:0]         irq_level
);

    localparam logic [NUM_SRC-1:0] ONLY_DBG0 = NUM_SRC'(1) << EXC_SRCS;
    localparam logic [NUM_SRC-1:0] ONLY_PER0 = NUM_SRC'(1) << (EXC_SRCS + NUM_DBG);
    localparam logic [VEC_W-1:0]   LOW_VEC   = VEC_BASE + VEC_W'(2 * (NUM_SRC - 1));
    localparam logic [VEC_W-1:0]   SPAN      = VEC_W'(2 * NUM_SRC);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!irq_valid && irq_vector == '0 && irq_level == 2'd0));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (irq_req == '0) |=> !irq_valid);

    assert_exc_top_R3: assert property (@(posedge clk) disable iff (rst)
        irq_req[0] |=> (irq_valid && irq_level == 2'd3 && irq_vector == VEC_BASE));

    assert_dbg_level_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_req == ONLY_DBG0 && dbg0_sel != 2'b00 && dbg0_sel >= core_mask)
        |=> (irq_valid && irq_level == $past(dbg0_sel)));

    assert_per_off_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_req == ONLY_PER0 && per0_sel == 2'b00) |=> !irq_valid);

    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_level < $past(core_mask)) |-> (irq_vector == LOW_VEC));

    assert_vec_slot_R9: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vector >= VEC_BASE && (irq_vector - VEC_BASE) < SPAN
                       && irq_vector[0] == VEC_BASE[0]));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
    .NUM_DBG  (NUM_DBG),
    .NUM_PER  (NUM_PER),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .dbg0_sel   (dbg_sel[1:0]),
    .per0_sel   (per_sel[1:0]),
    .core_mask  (core_mask),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .irq_level  (irq_level)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ND = 2;
    localparam int NP = 3;
    localparam int VW = 12;
    localparam logic [VW-1:0] BASE = 12'h100;
    localparam int N  = 7 + ND + NP + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_req;
    logic [3:0]    dbg_sel;
    logic [5:0]    per_sel;
    logic [1:0]    core_mask;
    logic          irq_valid;
    logic [VW-1:0] irq_vector;
    logic [1:0]    irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_prio_arbiter #(
        .NUM_DBG  (ND),
        .NUM_PER  (NP),
        .VEC_W    (VW),
        .VEC_BASE (BASE)
    ) u_irq_prio_arbiter (
        .clk        (clk),
        .rst        (rst),
        .irq_req    (irq_req),
        .dbg_sel    (dbg_sel),
        .per_sel    (per_sel),
        .core_mask  (core_mask),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector),
        .irq_level  (irq_level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected outcome from the requirements (R3..R10)
    function automatic void model(input logic [N-1:0] rq, input logic [3:0] ds,
                                  input logic [5:0] ps, input logic [1:0] m,
                                  output logic v, output logic [1:0] lv,
                                  output logic [VW-1:0] vec);
        int best = -1;
        int bl = -1;
        for (int i = 0; i < N - 1; i++) begin
            int l;
            if (i < 3) l = 3;
            else if (i < 7) l = 6 - i;
            else if (i < 7 + ND) l = (ds[2*(i-7) +: 2] == 2'b00) ? -1 : int'(ds[2*(i-7) +: 2]);
            else l = (ps[2*(i-7-ND) +: 2] == 2'b00) ? -1 : int'(ps[2*(i-7-ND) +: 2]) - 1;
            if (rq[i] && l >= 0 && l >= int'(m) && l > bl) begin
                bl = l;
                best = i;
            end
        end
        if (best < 0 && rq[N-1]) begin
            best = N - 1;
            bl = 0;
        end
        v   = (best >= 0);
        lv  = v ? 2'(bl) : 2'd0;
        vec = v ? BASE + VW'(2 * best) : '0;
    endfunction

    task automatic drive(input logic [N-1:0] rq, input logic [3:0] ds,
                         input logic [5:0] ps, input logic [1:0] m);
        irq_req   = rq;
        dbg_sel   = ds;
        per_sel   = ps;
        core_mask = m;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic ev, input logic [1:0] el,
                              input logic [VW-1:0] evec);
        checks++;
        if (irq_valid !== ev || (ev && (irq_level !== el || irq_vector !== evec))) begin
            errors++;
            $display("FAIL %s: got valid=%0b level=%0d vector=%h, expected valid=%0b level=%0d vector=%h",
                     tag, irq_valid, irq_level, irq_vector, ev, el, evec);
        end
    endtask

    task automatic run_model(input string tag, input logic [N-1:0] rq, input logic [3:0] ds,
                             input logic [5:0] ps, input logic [1:0] m);
        logic ev;
        logic [1:0] el;
        logic [VW-1:0] evec;
        drive(rq, ds, ps, m);
        model(rq, ds, ps, m, ev, el, evec);
        expect_out(tag, ev, el, evec);
    endtask

    function automatic logic [N-1:0] bit_of(input int i);
        return N'(1) << i;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [3:0] dA;
        logic [5:0] pA;
        rst = 1'b1;
        irq_req = bit_of(0);
        dbg_sel = '0;
        per_sel = '0;
        core_mask = '0;
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 1'b0, 2'd0, '0);
        checks++;
        if (irq_vector !== '0 || irq_level !== 2'd0) begin
            errors++;
            $display("FAIL R1 reset: got vector=%h level=%0d, expected vector=000 level=0",
                     irq_vector, irq_level);
        end
        rst = 1'b0;
        // set A: dbg0->1, dbg1->3, per0 off, per1->1, per2->2
        dA = 4'b11_01;
        pA = 6'b11_10_00;

        drive('0, dA, pA, 2'd0);
        expect_out("R2 no requests", 1'b0, 2'd0, '0);

        // R3: fixed levels of exceptions and traps, mask 0
        for (int i = 0; i < 7; i++) begin
            drive(bit_of(i), dA, pA, 2'd0);
            expect_out("R3 fixed level", 1'b1, (i < 3) ? 2'd3 : 2'(6 - i), BASE + VW'(2 * i));
        end

        // R4: every debug select code on debug source 0 (index 7)
        drive(bit_of(7), 4'b11_00, pA, 2'd0);
        expect_out("R4 dbg code 00 off", 1'b0, 2'd0, '0);
        for (int c = 1; c < 4; c++) begin
            drive(bit_of(7), {2'b11, 2'(c)}, pA, 2'd0);
            expect_out("R4 dbg code", 1'b1, 2'(c), BASE + 12'd14);
        end

        // R5: every peripheral select code on peripheral 0 (index 9)
        drive(bit_of(9), dA, 6'b11_10_00, 2'd0);
        expect_out("R5 per code 00 off", 1'b0, 2'd0, '0);
        for (int c = 1; c < 4; c++) begin
            drive(bit_of(9), dA, {4'b11_10, 2'(c)}, 2'd0);
            expect_out("R5 per code", 1'b1, 2'(c - 1), BASE + 12'd18);
        end

        // R6: per2 (level 2) beats dbg0 and trap #1 (level 1)
        drive(bit_of(11) | bit_of(7) | bit_of(5), dA, pA, 2'd0);
        expect_out("R6 higher level wins", 1'b1, 2'd2, BASE + 12'd22);

        // R7: dbg1 and illegal instruction both level 3, index 0 wins
        drive(bit_of(8) | bit_of(0), dA, pA, 2'd0);
        expect_out("R7 lowest index in level", 1'b1, 2'd3, BASE);
        drive(bit_of(10) | bit_of(7) | bit_of(5), dA, pA, 2'd0);
        expect_out("R7 lowest index level 1", 1'b1, 2'd1, BASE + 12'd10);

        // R8: mask gating
        drive(bit_of(6), dA, pA, 2'd0);
        expect_out("R8 level0 mask0", 1'b1, 2'd0, BASE + 12'd12);
        drive(bit_of(6), dA, pA, 2'd1);
        expect_out("R8 level0 mask1 blocked", 1'b0, 2'd0, '0);
        drive(bit_of(4), dA, pA, 2'd3);
        expect_out("R8 level2 mask3 blocked", 1'b0, 2'd0, '0);
        drive(bit_of(3), dA, pA, 2'd3);
        expect_out("R8 level3 mask3 passes", 1'b1, 2'd3, BASE + 12'd6);

        // R9: vector of the last numbered source
        drive(bit_of(11), dA, pA, 2'd2);
        expect_out("R9 vector slot", 1'b1, 2'd2, BASE + 12'd22);

        // R10: lowest software request
        drive(bit_of(12), dA, pA, 2'd3);
        expect_out("R10 low alone mask3", 1'b1, 2'd0, BASE + 12'd24);
        drive(bit_of(12) | bit_of(5), dA, pA, 2'd2);
        expect_out("R10 low under masked level1", 1'b1, 2'd0, BASE + 12'd24);
        drive(bit_of(12) | bit_of(6), dA, pA, 2'd0);
        expect_out("R10 preempted by level0", 1'b1, 2'd0, BASE + 12'd12);

        // exhaustive request sweep with set A under every mask (R6 R7 R8 R9 R10)
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < (1 << N); r++) begin
                run_model("R6 R7 R8 R9 R10 sweep", N'(r), dA, pA, 2'(m));
            end
        end

        // whole select space with pseudo-random requests (R4 R5 R8 R9)
        lfsr = 16'hACE1;
        for (int s = 0; s < 1024; s++) begin
            for (int k = 0; k < 32; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                run_model("R4 R5 R8 R9 select sweep", lfsr[N-1:0] & {N{lfsr[15]}} | (lfsr[N-1:0] & lfsr[14:2]),
                          s[3:0], s[9:4], lfsr[1:0]);
            end
        end

        // R2: back to idle after traffic
        drive('0, dA, pA, 2'd0);
        expect_out("R2 idle after traffic", 1'b0, 2'd0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule